// File: doc/BRIEF.md
# PLL Digital Lock Detector

This block watches the two inputs of a PLL phase detector, the reference edge and the feedback-divider edge, and decides whether the loop is locked. It runs on the VCO clock. For every pair of edges it counts the VCO cycles between them and keeps the result as a signed phase error. The sign tells which edge came first. Each completed comparison is then judged against a phase window. A narrow window applies while the loop is unlocked and a wider window applies once it is locked. A hysteretic counter turns the stream of in-phase and out-of-phase verdicts into a single lock flag.

Lock is declared only after a programmed number of in-phase verdicts in a row. It is withdrawn only after a programmed number of out-of-phase verdicts in a row. This lets the flag ride through the edge jitter that a fractional-N divider produces, which can move the divider edge by several VCO cycles plus a fraction of a cycle. One configuration bit hands lock detection to an external analogue detector. While that bit is set, this block is idle and holds its flag low.

Top module: `pll_lock_detect`

## Requirements
- R1: While reset is held and after it is released, `lock` is 0 and `phase_err` is 0. The event counter is cleared.
- R2: `phase_err` becomes the signed count of VCO cycles from the reference edge to the divider edge, one clock after the edge that completes the pair. The value is positive when the divider edge is later and negative when it is earlier. Two edges sampled in the same cycle give 0. The value holds until the next comparison completes.
- R3: While unlocked, a comparison is in phase when |phase_err| <= 2^k. Here k is the lock window code in `cfg_word[10:8]`.
- R4: While unlocked, each in-phase comparison adds one to the counter. When the counter reaches the lock threshold `cfg_word[7:4]`, `lock` rises and the counter clears. `lock` changes one clock after `phase_err` updates.
- R5: While unlocked, any out-of-phase comparison clears the counter, so lock requires consecutive in-phase comparisons.
- R6: While locked, a comparison is in phase when |phase_err| <= 4*2^m. Here m is the loss window code in `cfg_word[12:11]`. Each out-of-phase comparison adds one to the counter. When the counter reaches the loss threshold `cfg_word[3:0]`, `lock` falls and the counter clears.
- R7: While locked, any in-phase comparison clears the counter. Between comparisons `lock` does not change.
- R8: If the second edge of a pair has not arrived 255 cycles after the first, the comparison completes as out of phase. `phase_err` then reads +255 when the block was waiting for the divider edge, or -255 when it was waiting for the reference edge. A second edge arriving exactly 255 cycles after the first is still measured normally.
- R9: A threshold field of 0 behaves as a threshold of 1.
- R10: While `cfg_word[14]` is 1, `lock` is 0 from the next clock on and the counter is cleared. Any measurement in progress is abandoned, edges are ignored, and `phase_err` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_vco | input | 1 | VCO clock; all timing is counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_edge | input | 1 | One-cycle pulse marking a reference edge |
| div_edge | input | 1 | One-cycle pulse marking a divider edge |
| cfg_word | input | 16 | [14] analogue hand-off, [12:11] loss window, [10:8] lock window, [7:4] lock threshold, [3:0] loss threshold |
| lock | output | 1 | Lock verdict |
| phase_err | output | 9 | Signed last measured phase error in VCO cycles |

## Verification
Several events can land in the same cycle, and each collision is provoked on purpose:
- **Completion against timeout.** The edge that completes a measurement can coincide with the timeout count. The bench places the divider edge exactly 255 cycles after the reference edge, which must be measured as +255. A pair whose second edge never arrives must time out at the same count with the same reading.
- **Analogue hand-off against a completing edge.** The hand-off bit is raised in the very cycle the second edge is sampled. The hand-off must win: `phase_err` keeps its old value and `lock` drops.
- **Threshold against window switch.** The comparison that reaches the lock threshold is the one that switches the window. It is judged with the narrow window, and the comparisons after it with the wide one. A sweep of the error across both windows at their edges confirms this.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef enum logic [1:0] {
    MS_IDLE     = 2'd0,
    MS_WAIT_DIV = 2'd1,
    MS_WAIT_REF = 2'd2
  } meter_st_t;

  localparam int CFG_W      = 16;
  localparam int ANALOG_BIT = 14;
endpackage

// File: rtl/pld_phase_meter.sv
module pld_phase_meter #(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               ref_edge,
  input  logic               div_edge,
  output logic               res_vld,
  output logic               res_late,
  output logic signed [CNT_W:0] res_err
);
  import pld_pkg::*;

  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  meter_st_t          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               vld_q, vld_d;
  logic               late_q, late_d;
  logic signed [CNT_W:0] err_q, err_d;
  logic signed [CNT_W:0] cnt_pos;

  assign cnt_pos = $signed({1'b0, cnt_q});

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    vld_d  = 1'b0;
    late_d = 1'b0;
    err_d  = err_q;
    if (!en) begin
      st_d  = MS_IDLE;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        MS_IDLE: begin
          if (ref_edge && div_edge) begin
            vld_d = 1'b1;
            err_d = '0;
          end else if (ref_edge) begin
            st_d  = MS_WAIT_DIV;
            cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
          end else if (div_edge) begin
            st_d  = MS_WAIT_REF;
            cnt_d = {{(CNT_W-1){1'b0}}, 1'b1};
          end
        end
        MS_WAIT_DIV: begin
          if (div_edge || cnt_q == MAX_CNT) begin
            vld_d  = 1'b1;
            late_d = !div_edge;
            err_d  = cnt_pos;
            st_d   = MS_IDLE;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        MS_WAIT_REF: begin
          if (ref_edge || cnt_q == MAX_CNT) begin
            vld_d  = 1'b1;
            late_d = !ref_edge;
            err_d  = -cnt_pos;
            st_d   = MS_IDLE;
            cnt_d  = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = MS_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MS_IDLE;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
      late_q <= 1'b0;
      err_q  <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      vld_q  <= vld_d;
      late_q <= late_d;
      err_q  <= err_d;
    end
  end

  assign res_vld  = vld_q;
  assign res_late = late_q;
  assign res_err  = err_q;

  p_err_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> (res_err <= $signed({1'b0, MAX_CNT}) && res_err >= -$signed({1'b0, MAX_CNT})));

  p_late_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_late |-> (res_vld && (res_err == $signed({1'b0, MAX_CNT}) || res_err == -$signed({1'b0, MAX_CNT}))));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!res_vld && $stable(res_err)));
endmodule

// File: rtl/pld_window_judge.sv
module pld_window_judge #(
  parameter int CNT_W = 8,
  parameter int WK_W  = 3,
  parameter int WM_W  = 2
) (
  input  logic signed [CNT_W:0] err,
  input  logic                  late,
  input  logic                  locked,
  input  logic [WK_W-1:0]       lock_win,
  input  logic [WM_W-1:0]       loss_win,
  output logic                  in_phase
);
  logic [CNT_W:0] mag;
  logic [31:0]    lim_lock;
  logic [31:0]    lim_loss;
  logic [31:0]    lim_sel;

  always_comb begin
    mag      = err[CNT_W] ? $unsigned(-err) : $unsigned(err);
    lim_lock = 32'd1 << lock_win;
    lim_loss = 32'd4 << loss_win;
    lim_sel  = locked ? lim_loss : lim_lock;
    in_phase = !late && (32'(mag) <= lim_sel);
  end
endmodule

// File: rtl/pld_hyst_fsm.sv
module pld_hyst_fsm #(
  parameter int THR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             res_vld,
  input  logic             in_phase,
  input  logic [THR_W-1:0] thr_lock,
  input  logic [THR_W-1:0] thr_loss,
  output logic             locked
);
  logic             lock_q, lock_d;
  logic [THR_W-1:0] cnt_q, cnt_d;
  logic [THR_W:0]   cnt_inc;
  logic [THR_W:0]   lim_lock, lim_loss;

  always_comb begin
    cnt_inc  = {1'b0, cnt_q} + 1'b1;
    lim_lock = (thr_lock == '0) ? {{THR_W{1'b0}}, 1'b1} : {1'b0, thr_lock};
    lim_loss = (thr_loss == '0) ? {{THR_W{1'b0}}, 1'b1} : {1'b0, thr_loss};
    lock_d   = lock_q;
    cnt_d    = cnt_q;
    if (!en) begin
      lock_d = 1'b0;
      cnt_d  = '0;
    end else if (res_vld) begin
      if (lock_q == in_phase) begin
        cnt_d = '0;
      end else if (cnt_inc == (lock_q ? lim_loss : lim_lock)) begin
        lock_d = !lock_q;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_inc[THR_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      lock_q <= lock_d;
      cnt_q  <= cnt_d;
    end
  end

  assign locked = lock_q;

  p_rise_on_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(en && res_vld && in_phase));

  p_fall_on_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(!en || (res_vld && !in_phase)));

  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !res_vld) |=> $stable(lock_q));

  p_analog_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!lock_q && cnt_q == '0));
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect #(
  parameter int CNT_W = 8,
  parameter int THR_W = 4,
  parameter int WK_W  = 3,
  parameter int WM_W  = 2
) (
  input  logic             clk_vco,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             div_edge,
  input  logic [15:0]      cfg_word,
  output logic             lock,
  output logic [CNT_W:0]   phase_err
);
  import pld_pkg::*;

  localparam int TL_LO = THR_W;
  localparam int WK_LO = 2 * THR_W;
  localparam int WM_LO = WK_LO + WK_W;

  logic [1:0]             rst_sync;
  logic                   rst_int_n;
  logic                   en;
  logic                   res_vld, res_late, in_phase, locked;
  logic signed [CNT_W:0]  res_err;

  always_ff @(posedge clk_vco or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign en = !cfg_word[ANALOG_BIT];

  pld_phase_meter #(.CNT_W(CNT_W)) u_meter (
    .clk      (clk_vco),
    .rst_n    (rst_int_n),
    .en       (en),
    .ref_edge (ref_edge),
    .div_edge (div_edge),
    .res_vld  (res_vld),
    .res_late (res_late),
    .res_err  (res_err)
  );

  pld_window_judge #(.CNT_W(CNT_W), .WK_W(WK_W), .WM_W(WM_W)) u_judge (
    .err      (res_err),
    .late     (res_late),
    .locked   (locked),
    .lock_win (cfg_word[WK_LO +: WK_W]),
    .loss_win (cfg_word[WM_LO +: WM_W]),
    .in_phase (in_phase)
  );

  pld_hyst_fsm #(.THR_W(THR_W)) u_fsm (
    .clk      (clk_vco),
    .rst_n    (rst_int_n),
    .en       (en),
    .res_vld  (res_vld),
    .in_phase (in_phase),
    .thr_lock (cfg_word[TL_LO +: THR_W]),
    .thr_loss (cfg_word[0 +: THR_W]),
    .locked   (locked)
  );

  assign lock      = locked;
  assign phase_err = res_err;

  p_reset_quiet_r1: assert property (@(posedge clk_vco)
    !rst_int_n |=> (!lock && phase_err == '0));
endmodule

// File: tb/tb_pll_lock_detect.sv
module tb_pll_lock_detect;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk_vco = 1'b0;
  logic        rst_n;
  logic        ref_edge, div_edge;
  logic [15:0] cfg_word;
  logic        lock;
  logic [8:0]  phase_err;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  // reference model state
  bit m_locked;
  int m_cnt;
  int m_last;

  pll_lock_detect dut (
    .clk_vco(clk_vco), .rst_n(rst_n), .ref_edge(ref_edge), .div_edge(div_edge),
    .cfg_word(cfg_word), .lock(lock), .phase_err(phase_err)
  );

  always #(CLK_PERIOD/2) clk_vco = ~clk_vco;

  always @(posedge clk_vco) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] mk_cfg(bit ana, int m, int k, int tl, int tx);
    return {1'b0, ana, 1'b0, 2'(m), 3'(k), 4'(tl), 4'(tx)};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_vco);
    rst_n = 1'b0; ref_edge = 1'b0; div_edge = 1'b0;
    repeat (2) @(negedge clk_vco);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_vco);
    m_locked = 0; m_cnt = 0; m_last = 0;
  endtask

  function automatic void model(int d, bit late);
    int n    = d < 0 ? -d : d;
    int k    = int'(cfg_word[10:8]);
    int m    = int'(cfg_word[12:11]);
    int tl   = cfg_word[7:4] == 0 ? 1 : int'(cfg_word[7:4]);
    int tx   = cfg_word[3:0] == 0 ? 1 : int'(cfg_word[3:0]);
    int lim  = m_locked ? (4 << m) : (1 << k);
    bit ip   = !late && n <= lim;
    if (cfg_word[14]) begin
      m_locked = 0; m_cnt = 0;
      return;
    end
    m_last = late ? (d > 0 ? 255 : -255) : d;
    if (ip == m_locked) m_cnt = 0;
    else begin
      m_cnt++;
      if (m_cnt == (m_locked ? tx : tl)) begin
        m_locked = !m_locked; m_cnt = 0;
      end
    end
  endfunction

  // d > 0: reference first, divider d cycles later; d < 0: divider first.
  // |d| > 255 means the second edge is never sent (timeout).
  task automatic pair(int d, string req);
    int  n    = d < 0 ? -d : d;
    bit  late = n > 255;
    @(negedge clk_vco);
    if (d == 0) begin ref_edge = 1'b1; div_edge = 1'b1; end
    else if (d > 0) ref_edge = 1'b1;
    else div_edge = 1'b1;
    if (late) begin
      repeat (256) begin @(negedge clk_vco); ref_edge = 1'b0; div_edge = 1'b0; end
    end else begin
      for (int i = 1; i <= n; i++) begin
        @(negedge clk_vco);
        ref_edge = 1'b0; div_edge = 1'b0;
        if (i == n) begin
          if (d > 0) div_edge = 1'b1; else ref_edge = 1'b1;
        end
      end
      @(negedge clk_vco);
      ref_edge = 1'b0; div_edge = 1'b0;
    end
    model(d, late);
    chk(late ? "R8 timeout error" : "R2 phase error", int'($signed(phase_err)), m_last);
    @(negedge clk_vco);
    chk(req, int'(lock), int'(m_locked));
  endtask

  initial begin
    int seq [10] = '{1, 1, 5, 1, 1, 1, 6, 3, 6, 6};
    rst_n = 1'b0; ref_edge = 1'b0; div_edge = 1'b0;
    cfg_word = mk_cfg(0, 0, 0, 1, 1);
    repeat (3) @(negedge clk_vco);
    chk("R1 lock in reset", int'(lock), 0);
    chk("R1 phase_err in reset", int'(phase_err), 0);
    do_reset();
    chk("R1 lock after reset", int'(lock), 0);
    chk("R1 phase_err after reset", int'(phase_err), 0);

    // R3: sweep unlocked window, threshold field 0 acts as 1 (R9)
    for (int k = 0; k < 5; k++)
      for (int d = -20; d <= 20; d++) begin
        cfg_word = mk_cfg(0, 0, k, 0, 1);
        do_reset();
        pair(d, "R3 R9 unlocked window");
      end

    // R6: sweep locked window, loss threshold 0 acts as 1 (R9)
    for (int m = 0; m < 4; m++)
      for (int d = -40; d <= 40; d++) begin
        cfg_word = mk_cfg(0, m, 0, 1, 0);
        do_reset();
        pair(0, "R4 acquire");
        pair(d, "R6 R9 locked window");
      end

    // R4 R5 R6 R7: hysteresis sequence, lock thr 3, loss thr 2
    cfg_word = mk_cfg(0, 0, 1, 3, 2);
    do_reset();
    foreach (seq[i]) pair(seq[i], "R4 R5 R6 R7 sequence");
    chk("R6 unlocked at end", int'(lock), 0);

    // R8: boundary 255 measured, 256+ timeout both directions
    cfg_word = mk_cfg(0, 3, 7, 1, 1);
    do_reset();
    pair(0, "R4 acquire");
    pair(255, "R8 boundary out of phase");
    do_reset();
    pair(-255, "R8 boundary negative");
    pair(300, "R8 timeout positive");
    pair(-300, "R8 timeout negative");

    // R10: analogue hand-off
    cfg_word = mk_cfg(0, 0, 2, 1, 4);
    do_reset();
    pair(3, "R4 acquire");
    @(negedge clk_vco);
    cfg_word[14] = 1'b1;
    @(negedge clk_vco);
    chk("R10 lock drops", int'(lock), 0);
    m_locked = 0; m_cnt = 0;
    pair(2, "R10 idle lock");
    chk("R10 phase_err held", int'($signed(phase_err)), 3);
    // hand-off raised in the cycle the second edge is sampled
    cfg_word[14] = 1'b0;
    pair(1, "R4 reacquire");
    @(negedge clk_vco); ref_edge = 1'b1;
    @(negedge clk_vco); ref_edge = 1'b0;
    @(negedge clk_vco); div_edge = 1'b1; cfg_word[14] = 1'b1;
    @(negedge clk_vco); div_edge = 1'b0;
    chk("R10 coincident edge ignored", int'($signed(phase_err)), 1);
    @(negedge clk_vco);
    chk("R10 coincident lock low", int'(lock), 0);
    cfg_word[14] = 1'b0;
    m_locked = 0; m_cnt = 0;
    pair(-2, "R3 after hand-off");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule